// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block supplies the word address for every beat of a four-beat burst into a synchronous memory that is 32 bits wide. When either of two active-low address strobes is asserted, one for the processor and one for the memory controller, the block captures an external word address on the rising clock edge. On later cycles, an active-low advance input moves a two-bit beat counter forward. The two low address bits then follow either a linear order or an interleaved order. A static mode input chooses the order. The upper address bits keep the captured value.

The memory array sits beside this block and reads `word_addr` as its array address. The same holds for the write path and the output pipeline. `beat` tells the surrounding logic which beat of the burst is in progress. The address width, the beat width and the set of supported orders are all parameters. A generate block either builds both orders with a runtime selector or fixes a single order at elaboration.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset, with `rst_n` low at a rising edge, sets `beat` to 0 and `word_addr` to 0 from the following cycle.
- R2: At a rising edge where `strobe_cpu_n` or `strobe_ctl_n` is low, or both are low, the block captures `ext_addr`. From the next cycle `beat` is 0 and `word_addr` equals the captured address.
- R3: At a rising edge where `advance_n` is low and both strobes are high, `beat` increases by one modulo 4.
- R4: At a rising edge where both strobes and `advance_n` are high, `beat` and `word_addr` keep their values.
- R5: With `order_interleave` = 0, the low two bits of `word_addr` are (captured low bits + `beat`) mod 4.
- R6: With `order_interleave` = 1, the low two bits of `word_addr` are (captured low bits XOR `beat`). For example, a start of 1 gives 1, 0, 3, 2.
- R7: An advance after beat 3 wraps to beat 0 and returns to the first beat's address. Bits 16 to 2 of `word_addr` never change except when an address is captured, so no carry ever reaches them.
- R8: A strobe in the same cycle as an advance takes priority. The block reloads from `ext_addr` and sets `beat` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_interleave | input | 1 | Burst order: 1 selects interleaved, 0 selects linear (static) |
| ext_addr | input | 17 | External word address |
| word_addr | output | 17 | Address of the current beat |
| beat | output | 2 | Index of the current beat |

## Verification
Each strobe, advance and reset is registered once. Its effect on `beat` and `word_addr` is therefore due in the cycle that follows the rising edge that samples it. `word_addr` is built from registered state and the static mode input, so the mode has no further delay. The bench drives inputs on the falling edge and lets the rising edge take them. A behavioural model is updated at that point, and both outputs are compared at the next falling edge, exactly one register stage later. Hold cycles, wraps and simultaneous strobe-and-advance cycles are compared in the same way.

// File: rtl/burst_pkg.sv
package burst_pkg;

   // Which burst orders an instance can produce.
   typedef enum logic [1:0] {
      ORDER_RUNTIME         = 2'd0,
      ORDER_LINEAR_ONLY     = 2'd1,
      ORDER_INTERLEAVE_ONLY = 2'd2
   } order_opt_e;

   // Decoded per-cycle control.
   typedef struct packed {
      logic load;
      logic step;
   } burst_ctl_t;

endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
   import burst_pkg::*;
(
   input  logic       strobe_cpu_n,
   input  logic       strobe_ctl_n,
   input  logic       advance_n,
   output burst_ctl_t ctl
);

   always_comb begin
      ctl.load = ~strobe_cpu_n | ~strobe_ctl_n;
      // a strobe wins over advance
      ctl.step = ~advance_n & ~ctl.load;
   end

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] base
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         base <= '0;
      else if (load)
         base <= ext_addr;
   end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int BEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   output logic [BEAT_W-1:0] beat
);

   localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         beat <= '0;
      else if (load)
         beat <= '0;
      else if (step)
         beat <= beat + ONE;
   end

   // R2
   load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (beat == '0));

   // R3
   step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> ((beat - $past(beat)) == ONE));

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(beat));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_pkg::*;
#(
   parameter int         BEAT_W    = 2,
   parameter order_opt_e ORDER_OPT = ORDER_RUNTIME
) (
   input  logic [BEAT_W-1:0] start_lo,
   input  logic [BEAT_W-1:0] beat,
   input  logic              interleave,
   output logic [BEAT_W-1:0] lane
);

   logic [BEAT_W-1:0] lin_lane;
   logic [BEAT_W-1:0] ilv_lane;

   // sum wraps within BEAT_W bits: no carry leaves the lane
   assign lin_lane = start_lo + beat;

   for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
      assign ilv_lane[b] = start_lo[b] ^ beat[b];
   end

   if (ORDER_OPT == ORDER_LINEAR_ONLY) begin : g_lin
      assign lane = lin_lane;
   end else if (ORDER_OPT == ORDER_INTERLEAVE_ONLY) begin : g_ilv
      assign lane = ilv_lane;
   end else begin : g_sel
      assign lane = interleave ? ilv_lane : lin_lane;
   end

   // R5
   always_comb begin
      if ((ORDER_OPT == ORDER_LINEAR_ONLY) ||
          ((ORDER_OPT == ORDER_RUNTIME) && !interleave))
         lin_lane_chk: assert ((beat == '0) -> (lane == start_lo));
   end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_pkg::*;
#(
   parameter int         ADDR_W    = 17,
   parameter int         BEAT_W    = 2,
   parameter order_opt_e ORDER_OPT = ORDER_RUNTIME
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_cpu_n,
   input  logic              strobe_ctl_n,
   input  logic              advance_n,
   input  logic              order_interleave,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] word_addr,
   output logic [BEAT_W-1:0] beat
);

   localparam int HI_W = ADDR_W - BEAT_W;

   if (BEAT_W < 1 || HI_W < 1) begin : g_bad_cfg
      $error("burst_addr_gen: ADDR_W must exceed BEAT_W and BEAT_W must be >= 1");
   end

   burst_ctl_t        ctl;
   logic [ADDR_W-1:0] base;
   logic [BEAT_W-1:0] lane;

   burst_ctl_decode u_dec (
      .strobe_cpu_n (strobe_cpu_n),
      .strobe_ctl_n (strobe_ctl_n),
      .advance_n    (advance_n),
      .ctl          (ctl)
   );

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctl.load),
      .ext_addr (ext_addr),
      .base     (base)
   );

   burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ctl.load),
      .step  (ctl.step),
      .beat  (beat)
   );

   burst_order_map #(.BEAT_W(BEAT_W), .ORDER_OPT(ORDER_OPT)) u_map (
      .start_lo   (base[BEAT_W-1:0]),
      .beat       (beat),
      .interleave (order_interleave),
      .lane       (lane)
   );

   assign word_addr = {base[ADDR_W-1:BEAT_W], lane};

   // R2
   load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.load |=> (word_addr == $past(ext_addr)));

   // R7
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.load |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

   // R8
   strobe_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.load && !advance_n) |=> (beat == '0));

endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strobe_cpu_n = 1'b1;
   logic        strobe_ctl_n = 1'b1;
   logic        advance_n = 1'b1;
   logic        order_interleave = 1'b0;
   logic [16:0] ext_addr = '0;
   logic [16:0] word_addr;
   logic [1:0]  beat;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   int m_base = 0;
   int m_beat = 0;

   always #10 clk = ~clk;

   burst_addr_gen dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .strobe_cpu_n     (strobe_cpu_n),
      .strobe_ctl_n     (strobe_ctl_n),
      .advance_n        (advance_n),
      .order_interleave (order_interleave),
      .ext_addr         (ext_addr),
      .word_addr        (word_addr),
      .beat             (beat)
   );

   function automatic int exp_addr();
      int lo;
      lo = order_interleave ? ((m_base & 3) ^ m_beat)
                            : (((m_base & 3) + m_beat) % 4);
      return (m_base & 'h1FFFC) | lo;
   endfunction

   // Entered at a falling edge; drives, takes one rising edge, compares at the next falling edge.
   task automatic cycle(input bit r_n, input bit cpu_n, input bit ctl_n,
                        input bit adv_n, input int addr, input string tag);
      rst_n        = r_n;
      strobe_cpu_n = cpu_n;
      strobe_ctl_n = ctl_n;
      advance_n    = adv_n;
      ext_addr     = 17'(addr);
      @(posedge clk);
      if (!r_n) begin
         m_base = 0; m_beat = 0;
      end else if (!cpu_n || !ctl_n) begin
         m_base = addr & 'h1FFFF; m_beat = 0;
      end else if (!adv_n) begin
         m_beat = (m_beat + 1) % 4;
      end
      @(negedge clk);
      checks++;
      if (int'(beat) != m_beat) begin
         failures++;
         $display("FAIL %s beat actual=%0d expected=%0d", tag, beat, m_beat);
      end
      checks++;
      if (int'(word_addr) != exp_addr()) begin
         failures++;
         $display("FAIL %s word_addr actual=%05h expected=%05h", tag, word_addr, exp_addr());
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(negedge clk);
      // R1: reset state
      cycle(0, 1, 1, 1, 0, "R1");
      cycle(0, 0, 1, 0, 'h1ABCD, "R1");

      // Linear order
      order_interleave = 1'b0;
      cycle(1, 0, 1, 1, 'h12345, "R2");
      for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 0, "R5");
      cycle(1, 1, 1, 0, 0, "R7");
      cycle(1, 1, 1, 0, 0, "R3");
      cycle(1, 1, 1, 1, 'h00000, "R4");
      cycle(1, 1, 1, 1, 'h1FFFF, "R4");
      cycle(1, 1, 0, 0, 'h1FFFF, "R8");
      for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 0, "R5");
      cycle(1, 1, 1, 0, 0, "R7");
      cycle(1, 1, 1, 0, 0, "R7");
      cycle(1, 0, 1, 0, 'h0000E, "R8");
      cycle(1, 1, 1, 0, 0, "R5");
      cycle(1, 1, 1, 0, 0, "R5");

      // Interleaved order
      order_interleave = 1'b1;
      cycle(1, 1, 0, 1, 'h0ABC5, "R2");
      for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 0, "R6");
      cycle(1, 1, 1, 0, 0, "R7");
      cycle(1, 1, 1, 1, 0, "R4");
      cycle(1, 0, 0, 1, 'h00002, "R2");
      for (int i = 0; i < 3; i++) cycle(1, 1, 1, 0, 0, "R6");
      cycle(1, 0, 1, 1, 'h1FFFB, "R2");
      for (int i = 0; i < 4; i++) cycle(1, 1, 1, 0, 0, "R6");
      cycle(1, 1, 0, 0, 'h05550, "R8");
      cycle(1, 1, 1, 0, 0, "R6");

      // R1: reset in mid-burst
      cycle(0, 1, 1, 0, 0, "R1");
      cycle(1, 1, 1, 1, 0, "R1");
      finish_run();
   end

endmodule